// File: doc/BRIEF.md
# Idle-Timeout Memory Low-Power Sequencer

This block sits next to a DRAM controller's command scheduler and watches how many host commands are still outstanding. The channel counts as idle only while that count is zero. Once the channel has stayed idle long enough, the block asks the memory side to enter power-down. If the channel stays idle longer still, it asks for self-refresh. A separate request input moves the memory into deep power-down. While in deep power-down, the block holds the memory there for a programmed minimum residency before it lets it leave.

Each low-power state has its own level request and acknowledge pair. A request is raised to enter the state and dropped to leave it, and the sequencer waits for the acknowledge to follow in both directions. All timing comes from one 32-bit configuration word. The two idle timeouts are counted in ticks of a shared divide-by-32 prescaler. The deep power-down residency is counted in ticks of a divide-by-4096 prescaler.

Top module: `lp_idle_seq`

## Requirements
- R1: The configuration word resets to 0x00402010. The self-refresh timeout sits in bits 23:16, the deep power-down minimum in bits 15:8 and the power-down timeout in bits 4:0. These fields read back as written, and every other bit reads zero.
- R2: The idle count restarts whenever the outstanding-command count is non-zero for even one cycle. After a restart, a full timeout of consecutive idle cycles is needed again.
- R3: With the power-down enable set and timeout T, `pd_req` is still low after the 32·T-th consecutive rising edge at which the command count is zero. It is high after the next edge.
- R4: A timeout field of zero, or a cleared enable, prevents the matching automatic entry no matter how long the channel is idle.
- R5: The self-refresh request follows the same 32·S+1 edge timing. When both timeouts expire together, self-refresh is requested and power-down is not.
- R6: From an active power-down, reaching the self-refresh timeout drops `pd_req`. Once `pd_ack` falls, the block raises `sr_req`.
- R7: An entry completes only after its acknowledge rises, and the request stays high until then even if commands arrive. In an entered state, a non-zero command count drops the request on the next edge. The block returns to normal only after the acknowledge falls.
- R8: While idle and in the normal state, `dpd_enter` raises `dpd_req`. Once deep power-down is acknowledged, the block holds `dpd_req` high for at least M·4096 cycles (M is the minimum field) before honouring an exit. An exit is requested by a low `dpd_enter` or a busy channel. With M=0, the exit happens at once.
- R9: A configuration write made outside the normal state is held and does not change the read value. It takes effect once the sequencer is back in the normal state.
- R10: At most one of `pd_req`, `sr_req` and `dpd_req` is high at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data (applied value) |
| cmd_pending | input | CNT_W | Number of outstanding host commands |
| pd_enable | input | 1 | Allow automatic power-down |
| sr_enable | input | 1 | Allow automatic self-refresh |
| dpd_enter | input | 1 | Deep power-down request from the power manager |
| pd_req | output | 1 | Power-down request |
| pd_ack | input | 1 | Power-down acknowledge |
| sr_req | output | 1 | Self-refresh request |
| sr_ack | input | 1 | Self-refresh acknowledge |
| dpd_req | output | 1 | Deep power-down request |
| dpd_ack | input | 1 | Deep power-down acknowledge |

## Verification
The hardest case to reach is the power-down to self-refresh upgrade. It requires power-down to be entered first, and then the channel must stay idle across several prescaler restarts caused by the state changes until the longer timeout expires. The bench sets a power-down timeout of one tick and a self-refresh timeout of four. It keeps the channel idle while an acknowledge responder follows the requests, then waits for `sr_req` and checks that `pd_req` has already dropped. The exact residency edge in deep power-down is reached in the same way. The minimum field is set to one unit, and the bench counts edges from the request to the exit.

// File: rtl/lp_seq_pkg.sv
package lp_seq_pkg;

  localparam int UNIT_W = 8;
  localparam int PDTO_W = 5;
  localparam int CFG_W  = 32;
  localparam logic [CFG_W-1:0] CFG_RESET = 32'h0040_2010;

  typedef enum logic [3:0] {
    ST_ACTIVE, ST_PD_ENT, ST_PD, ST_PD_EXT, ST_PD_SWAP,
    ST_SR_ENT, ST_SR, ST_SR_EXT, ST_DPD_ENT, ST_DPD, ST_DPD_EXT
  } lp_state_e;

  typedef struct packed {
    logic [UNIT_W-1:0] sr_to;
    logic [UNIT_W-1:0] dpd_min;
    logic [PDTO_W-1:0] pd_to;
  } lp_cfg_t;

  function automatic lp_cfg_t cfg_from_word(input logic [CFG_W-1:0] w);
    lp_cfg_t c;
    c.sr_to   = w[23:16];
    c.dpd_min = w[15:8];
    c.pd_to   = w[4:0];
    return c;
  endfunction

  function automatic logic [CFG_W-1:0] cfg_to_word(input lp_cfg_t c);
    return {8'h00, c.sr_to, c.dpd_min, 3'b000, c.pd_to};
  endfunction

  function automatic logic timeout_hit(input logic en,
                                       input logic [UNIT_W-1:0] limit,
                                       input logic [UNIT_W-1:0] units);
    return en && (limit != '0) && (units >= limit);
  endfunction

endpackage

// File: rtl/lp_timing_regs.sv
module lp_timing_regs
  import lp_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [CFG_W-1:0] wdata,
  input  logic             apply_ok,
  output lp_cfg_t          cfg,
  output logic [CFG_W-1:0] rdata
);

  lp_cfg_t pend_cfg;
  logic    pend_vld;
  logic    unused_wbits;

  assign unused_wbits = ^{wdata[31:24], wdata[7:5]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg      <= cfg_from_word(CFG_RESET);
      pend_cfg <= cfg_from_word(CFG_RESET);
      pend_vld <= 1'b0;
    end else if (wr) begin
      if (apply_ok) begin
        cfg      <= cfg_from_word(wdata);
        pend_vld <= 1'b0;
      end else begin
        pend_cfg <= cfg_from_word(wdata);
        pend_vld <= 1'b1;
      end
    end else if (pend_vld && apply_ok) begin
      cfg      <= pend_cfg;
      pend_vld <= 1'b0;
    end
  end

  assign rdata = cfg_to_word(cfg);

  // R9: outside the normal state the applied value never moves
  assert_held_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(apply_ok) |-> $stable(rdata));

endmodule

// File: rtl/lp_idle_timer.sv
module lp_idle_timer
  import lp_seq_pkg::*;
#(
  parameter int PRE_W     = 5,
  parameter int RES_PRE_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              idle,
  input  logic              state_chg,
  input  logic              idle_block,
  input  logic              res_run,
  input  logic [UNIT_W-1:0] dpd_min,
  output logic [UNIT_W-1:0] idle_units,
  output logic              dpd_min_met
);

  localparam logic [PRE_W-1:0]     PRE_MAX  = {PRE_W{1'b1}};
  localparam logic [RES_PRE_W-1:0] RES_MAX  = {RES_PRE_W{1'b1}};
  localparam logic [UNIT_W-1:0]    UNIT_MAX = {UNIT_W{1'b1}};

  logic [PRE_W-1:0]     pre_idle;
  logic [RES_PRE_W-1:0] pre_res;
  logic [UNIT_W-1:0]    res_units;
  logic                 tick_idle;
  logic                 tick_res;

  assign tick_idle = idle && !state_chg && (pre_idle == PRE_MAX);
  assign tick_res  = res_run && !state_chg && (pre_res == RES_MAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_idle <= '0;
    else if (!idle || state_chg) pre_idle <= '0;
    else pre_idle <= pre_idle + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idle_units <= '0;
    else if (!idle || idle_block) idle_units <= '0;
    else if (tick_idle && idle_units != UNIT_MAX) idle_units <= idle_units + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_res <= '0;
    else if (!res_run || state_chg) pre_res <= '0;
    else pre_res <= pre_res + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) res_units <= '0;
    else if (!res_run) res_units <= '0;
    else if (tick_res && res_units != UNIT_MAX) res_units <= res_units + 1'b1;
  end

  assign dpd_min_met = res_units >= dpd_min;

  // R2: one busy cycle leaves no idle credit behind
  assert_idle_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(idle) |-> (idle_units == '0));

endmodule

// File: rtl/lp_state_ctrl.sv
module lp_state_ctrl
  import lp_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              idle,
  input  logic              pd_en,
  input  logic              sr_en,
  input  logic              dpd_cmd,
  input  logic              pd_ack,
  input  logic              sr_ack,
  input  logic              dpd_ack,
  input  logic [PDTO_W-1:0] pd_to,
  input  logic [UNIT_W-1:0] sr_to,
  input  logic [UNIT_W-1:0] idle_units,
  input  logic              dpd_min_met,
  output lp_state_e         state,
  output logic              state_chg,
  output logic              pd_req,
  output logic              sr_req,
  output logic              dpd_req
);

  lp_state_e nxt;
  logic      pd_hit;
  logic      sr_hit;
  logic      dpd_leave;

  assign pd_hit    = timeout_hit(pd_en, {{(UNIT_W-PDTO_W){1'b0}}, pd_to}, idle_units);
  assign sr_hit    = timeout_hit(sr_en, sr_to, idle_units);
  assign dpd_leave = (!dpd_cmd || !idle) && dpd_min_met;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_ACTIVE: begin
        if (idle && dpd_cmd)     nxt = ST_DPD_ENT;
        else if (idle && sr_hit) nxt = ST_SR_ENT;
        else if (idle && pd_hit) nxt = ST_PD_ENT;
      end
      ST_PD_ENT:  if (pd_ack) nxt = ST_PD;
      ST_PD: begin
        if (!idle)       nxt = ST_PD_EXT;
        else if (sr_hit) nxt = ST_PD_SWAP;
      end
      ST_PD_EXT:  if (!pd_ack) nxt = ST_ACTIVE;
      ST_PD_SWAP: if (!pd_ack) nxt = idle ? ST_SR_ENT : ST_ACTIVE;
      ST_SR_ENT:  if (sr_ack) nxt = ST_SR;
      ST_SR:      if (!idle) nxt = ST_SR_EXT;
      ST_SR_EXT:  if (!sr_ack) nxt = ST_ACTIVE;
      ST_DPD_ENT: if (dpd_ack) nxt = ST_DPD;
      ST_DPD:     if (dpd_leave) nxt = ST_DPD_EXT;
      ST_DPD_EXT: if (!dpd_ack) nxt = ST_ACTIVE;
      default:    nxt = ST_ACTIVE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_ACTIVE;
    else        state <= nxt;
  end

  assign state_chg = (nxt != state);
  assign pd_req    = (state == ST_PD_ENT)  || (state == ST_PD);
  assign sr_req    = (state == ST_SR_ENT)  || (state == ST_SR);
  assign dpd_req   = (state == ST_DPD_ENT) || (state == ST_DPD);

  // R10: requests are mutually exclusive
  assert_one_request_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pd_req, sr_req, dpd_req}));

  // R8: deep power-down is left only after the residency counter agrees
  assert_dpd_residency_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dpd_req) |-> $past(dpd_min_met));

  // R7: a busy channel in entered power-down drops the request next edge
  assert_pd_exit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_PD && !idle) |=> !pd_req);

  // R3: power-down is only requested out of an idle channel
  assert_pd_from_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pd_req) |-> $past(idle));

endmodule

// File: rtl/lp_idle_seq.sv
module lp_idle_seq
  import lp_seq_pkg::*;
#(
  parameter int CNT_W     = 6,
  parameter int PRE_W     = 5,
  parameter int RES_PRE_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic [31:0]      cfg_wdata,
  output logic [31:0]      cfg_rdata,
  input  logic [CNT_W-1:0] cmd_pending,
  input  logic             pd_enable,
  input  logic             sr_enable,
  input  logic             dpd_enter,
  output logic             pd_req,
  input  logic             pd_ack,
  output logic             sr_req,
  input  logic             sr_ack,
  output logic             dpd_req,
  input  logic             dpd_ack
);

  lp_cfg_t           cfg;
  lp_state_e         state;
  logic              state_chg;
  logic              idle;
  logic [UNIT_W-1:0] idle_units;
  logic              dpd_min_met;
  logic              in_dpd_any;

  assign idle       = (cmd_pending == '0);
  assign in_dpd_any = (state == ST_DPD_ENT) || (state == ST_DPD) || (state == ST_DPD_EXT);

  lp_timing_regs u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr       (cfg_wr),
    .wdata    (cfg_wdata),
    .apply_ok (state == ST_ACTIVE),
    .cfg      (cfg),
    .rdata    (cfg_rdata)
  );

  lp_idle_timer #(.PRE_W(PRE_W), .RES_PRE_W(RES_PRE_W)) u_timer (
    .clk         (clk),
    .rst_n       (rst_n),
    .idle        (idle),
    .state_chg   (state_chg),
    .idle_block  (in_dpd_any),
    .res_run     (state == ST_DPD),
    .dpd_min     (cfg.dpd_min),
    .idle_units  (idle_units),
    .dpd_min_met (dpd_min_met)
  );

  lp_state_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .idle        (idle),
    .pd_en       (pd_enable),
    .sr_en       (sr_enable),
    .dpd_cmd     (dpd_enter),
    .pd_ack      (pd_ack),
    .sr_ack      (sr_ack),
    .dpd_ack     (dpd_ack),
    .pd_to       (cfg.pd_to),
    .sr_to       (cfg.sr_to),
    .idle_units  (idle_units),
    .dpd_min_met (dpd_min_met),
    .state       (state),
    .state_chg   (state_chg),
    .pd_req      (pd_req),
    .sr_req      (sr_req),
    .dpd_req     (dpd_req)
  );

endmodule

// File: tb/lp_idle_seq_test.sv
module lp_idle_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic [5:0]  cmd_pending = 6'd1;
  logic        pd_enable = 1'b0, sr_enable = 1'b0, dpd_enter = 1'b0;
  logic        pd_req, sr_req, dpd_req;
  logic        pd_ack = 1'b0, sr_ack = 1'b0, dpd_ack = 1'b0;
  logic        hold_ack = 1'b0;
  int          checks = 0, errors = 0, cyc = 0, multi_req = 0;

  lp_idle_seq uut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .cmd_pending(cmd_pending), .pd_enable(pd_enable),
    .sr_enable(sr_enable), .dpd_enter(dpd_enter), .pd_req(pd_req),
    .pd_ack(pd_ack), .sr_req(sr_req), .sr_ack(sr_ack), .dpd_req(dpd_req),
    .dpd_ack(dpd_ack)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // memory-side responder: acknowledge follows request half a cycle later
  always @(negedge clk) begin
    if (!hold_ack) begin
      pd_ack  <= pd_req;
      sr_ack  <= sr_req;
      dpd_ack <= dpd_req;
    end
    if (rst_n && (int'(pd_req) + int'(sr_req) + int'(dpd_req)) > 1) multi_req++;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > WATCHDOG) begin
      errors++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  function automatic logic [31:0] mkcfg(input int sr, input int dpd, input int pd);
    return ((sr & 32'hFF) << 16) | ((dpd & 32'hFF) << 8) | (pd & 32'h1F);
  endfunction

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_cfg(input logic [31:0] v);
    cfg_wr = 1'b1; cfg_wdata = v;
    step(1);
    cfg_wr = 1'b0;
  endtask

  task automatic settle();
    cmd_pending = 6'd1; dpd_enter = 1'b0; hold_ack = 1'b0;
    step(6);
  endtask

  task automatic t_reset();
    chk(cfg_rdata == 32'h0040_2010, "R1 reset value", cfg_rdata, 32'h0040_2010);
    chk({pd_req, sr_req, dpd_req} == 3'b000, "R1 reset requests", {pd_req, sr_req, dpd_req}, 0);
  endtask

  task automatic t_readback();
    wr_cfg(32'hFFFF_FFFF);
    chk(cfg_rdata == 32'h00FF_FF1F, "R1 field mask", cfg_rdata, 32'h00FF_FF1F);
    wr_cfg(32'h0012_3405);
    chk(cfg_rdata == 32'h0012_3405, "R1 readback", cfg_rdata, 32'h0012_3405);
  endtask

  task automatic t_pd_timing();
    settle();
    pd_enable = 1'b1; sr_enable = 1'b0;
    wr_cfg(mkcfg(0, 0, 2));
    cmd_pending = 0;
    step(64);
    chk(pd_req == 1'b0, "R3 pd_req before 32*T", pd_req, 0);
    step(1);
    chk(pd_req == 1'b1, "R3 pd_req at 32*T+1", pd_req, 1);
    step(3);
    chk(pd_req == 1'b1, "R7 pd held after ack", pd_req, 1);
    cmd_pending = 2;
    step(1);
    chk(pd_req == 1'b0, "R7 pd exit on command", pd_req, 0);
    settle();
  endtask

  task automatic t_restart();
    pd_enable = 1'b1; sr_enable = 1'b0;
    wr_cfg(mkcfg(0, 0, 1));
    cmd_pending = 0;
    step(20);
    cmd_pending = 1;
    step(1);
    cmd_pending = 0;
    step(32);
    chk(pd_req == 1'b0, "R2 restart after busy cycle", pd_req, 0);
    step(1);
    chk(pd_req == 1'b1, "R2 full timeout after restart", pd_req, 1);
    settle();
  endtask

  task automatic t_disabled();
    pd_enable = 1'b1; sr_enable = 1'b1;
    wr_cfg(mkcfg(0, 0, 0));
    cmd_pending = 0;
    step(400);
    chk({pd_req, sr_req} == 2'b00, "R4 zero timeouts", {pd_req, sr_req}, 0);
    settle();
    pd_enable = 1'b0; sr_enable = 1'b0;
    wr_cfg(mkcfg(1, 0, 1));
    cmd_pending = 0;
    step(200);
    chk({pd_req, sr_req} == 2'b00, "R4 enables cleared", {pd_req, sr_req}, 0);
    settle();
  endtask

  task automatic t_priority();
    pd_enable = 1'b1; sr_enable = 1'b1;
    wr_cfg(mkcfg(2, 0, 2));
    cmd_pending = 0;
    step(64);
    chk(sr_req == 1'b0, "R5 sr_req before 32*S", sr_req, 0);
    step(1);
    chk(sr_req == 1'b1, "R5 sr_req at 32*S+1", sr_req, 1);
    chk(pd_req == 1'b0, "R5 power-down suppressed", pd_req, 0);
    settle();
  endtask

  task automatic t_upgrade();
    int waited;
    pd_enable = 1'b1; sr_enable = 1'b1;
    wr_cfg(mkcfg(4, 0, 1));
    cmd_pending = 0;
    step(35);
    chk(pd_req == 1'b1, "R6 power-down first", pd_req, 1);
    waited = 0;
    while (!sr_req && waited < 400) begin
      step(1);
      waited++;
    end
    chk(sr_req == 1'b1, "R6 upgrade to self-refresh", sr_req, 1);
    chk(pd_req == 1'b0, "R6 pd dropped on upgrade", pd_req, 0);
    settle();
  endtask

  task automatic t_handshake_and_hold();
    pd_enable = 1'b0; sr_enable = 1'b1;
    wr_cfg(mkcfg(1, 0, 0));
    hold_ack = 1'b1;
    cmd_pending = 0;
    step(33);
    chk(sr_req == 1'b1, "R7 sr entry requested", sr_req, 1);
    cmd_pending = 3;
    step(5);
    chk(sr_req == 1'b1, "R7 request held until ack", sr_req, 1);
    cmd_pending = 0;
    hold_ack = 1'b0;
    step(3);
    chk(sr_req == 1'b1, "R7 in self-refresh", sr_req, 1);
    wr_cfg(mkcfg(9, 3, 7));
    chk(cfg_rdata == mkcfg(1, 0, 0), "R9 write held in low power", cfg_rdata, mkcfg(1, 0, 0));
    cmd_pending = 3;
    step(1);
    chk(sr_req == 1'b0, "R7 sr exit next edge", sr_req, 0);
    step(4);
    chk(cfg_rdata == mkcfg(9, 3, 7), "R9 held write applied", cfg_rdata, mkcfg(9, 3, 7));
    settle();
  endtask

  task automatic t_dpd();
    pd_enable = 1'b0; sr_enable = 1'b0;
    wr_cfg(mkcfg(0, 1, 0));
    cmd_pending = 0;
    dpd_enter = 1'b1;
    step(2);
    chk(dpd_req == 1'b1, "R8 deep power-down entered", dpd_req, 1);
    dpd_enter = 1'b0;
    step(4096);
    chk(dpd_req == 1'b1, "R8 residency not yet met", dpd_req, 1);
    step(1);
    chk(dpd_req == 1'b0, "R8 exit after residency", dpd_req, 0);
    settle();
    wr_cfg(mkcfg(0, 0, 0));
    cmd_pending = 0;
    dpd_enter = 1'b1;
    step(2);
    dpd_enter = 1'b0;
    step(1);
    chk(dpd_req == 1'b0, "R8 zero residency exits at once", dpd_req, 0);
    settle();
  endtask

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    t_reset();
    t_readback();
    t_pd_timing();
    t_restart();
    t_disabled();
    t_priority();
    t_upgrade();
    t_handshake_and_hold();
    t_dpd();
    chk(multi_req == 0, "R10 single request", multi_req, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule